// File: doc/BRIEF.md
# Configurable-Sense Interrupt Source Detector

This block is a bank of per-source detectors that sits in front of an interrupt arbiter. Once per clock it samples every synchronous request line. It keeps the level seen on the previous clock for each source and applies that source's 2-bit sense mode: level, falling edge, rising edge or both edges. From this it sets or clears the source's pending flag and raises a one-cycle request strobe towards the arbiter.

Sources in a configurable window of external pins (sources 64 to 95 by default) have a software-programmable sense mode, set through one control byte per pin. Every other source keeps the mode it takes at reset. Software can also clear the pending flag of an edge-sensed source. The arbiter reports which source it is currently presenting to the CPU. When that source is level-sensed and its line has dropped, the block tells the arbiter to withdraw the request.

Top module: `sense_detector_array`

## Requirements
- R1: At reset, the pending flags, the request strobes, the withdraw strobe and the stored previous levels are all 0. Sources set in `LEVEL_MASK` (default: 64 to 67 and 200) start in level mode (code 0). Every other source starts in rising-edge mode (code 2).
- R2: Level mode (code 0): after each clock edge, a source's pending flag and request strobe both equal the line level sampled at that edge. A low line therefore clears the flag.
- R3: Rising mode (code 2): a sample of 1 whose stored previous level is 0 sets the pending flag and pulses the request strobe for one cycle. Otherwise the flag is held.
- R4: Falling mode (code 1): a sample of 0 whose stored previous level is 1 sets the pending flag and pulses the request strobe for one cycle.
- R5: Both-edges mode (code 3): any difference between the sample and the stored previous level sets the pending flag and pulses the request strobe.
- R6: The previous level is stored in every mode. After a source changes from level mode to an edge mode while its line stays high, no event is detected.
- R7: A write with `wr_pin_i`=1 to address k (k < 32) loads bits 3:2 of the data into the mode of source 64+k. Other data bits are ignored, and addresses of 32 and above have no effect. A pin-control read returns the mode in bits 3:2 and zeros elsewhere, one cycle after the request.
- R8: A write of 0x00 with `wr_pin_i`=0 to address n clears the pending flag of source n only when that source is edge-sensed. Non-zero data, and writes to level-sensed sources, leave the flag unchanged.
- R9: A pending read (`rd_pin_i`=0) returns the source's pending flag in bit 0 and zeros in bits 7:1, one cycle after the request.
- R10: `cancel_o` pulses for one cycle after an edge at which the presented source is valid, is in level mode, and has a low line. It never pulses for an edge-sensed source or when no source is presented.
- R11: When a detected event and a software clear hit the same source at the same edge, the pending flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_line_i | input | NUM_SRC | Synchronous request line of each source |
| wr_en_i | input | 1 | Software write strobe |
| wr_pin_i | input | 1 | Write target: 1 = pin control byte, 0 = pending byte |
| wr_addr_i | input | SRC_AW | Write address (source number or pin number) |
| wr_data_i | input | 8 | Write data |
| rd_pin_i | input | 1 | Read target: 1 = pin control byte, 0 = pending byte |
| rd_addr_i | input | SRC_AW | Read address |
| pres_valid_i | input | 1 | Arbiter is presenting a source to the CPU |
| pres_idx_i | input | SRC_AW | Source currently presented |
| pend_o | output | NUM_SRC | Registered pending flags |
| req_o | output | NUM_SRC | Registered one-cycle request strobes to the arbiter |
| cancel_o | output | 1 | Registered withdraw strobe for the presented level request |
| rd_data_o | output | 8 | Registered read data |

## Verification
A stale previous-level bit shows up one clock later as a spurious or missing request strobe on the next edge-sensed sample. A wrong mode register shows up the same way, and can be seen directly by reading back the pin control byte. A pending flag that is cleared, or not cleared, at the wrong time appears on `pend_o` at the very next edge. Through the read port it appears one cycle later. A wrong choice of which source is presented, or of its mode, shows as a `cancel_o` pulse that is extra or missing exactly one cycle after the sample.

// File: rtl/sense_det_pkg.sv
package sense_det_pkg;

  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'd0,
    SENSE_FALL  = 2'd1,
    SENSE_RISE  = 2'd2,
    SENSE_BOTH  = 2'd3
  } sense_e;

  // bit position of the mode field inside a pin control byte
  localparam int MODE_LSB = 2;

endpackage

// File: rtl/sense_cell.sv
module sense_cell
  import sense_det_pkg::*;
#(
  parameter logic [1:0] RST_MODE = SENSE_RISE,
  parameter bit         PROG     = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_i,
  input  logic       clr_i,
  input  logic       mode_we_i,
  input  logic [1:0] mode_wval_i,
  output logic [1:0] mode_o,
  output logic       pend_o,
  output logic       req_o
);

  logic   prev_q;
  logic   rise, fall, hit;
  sense_e mode_e;

  assign mode_e = sense_e'(mode_o);

  always_comb begin
    rise = line_i & ~prev_q;
    fall = ~line_i & prev_q;
    unique case (mode_e)
      SENSE_LEVEL: hit = line_i;
      SENSE_FALL:  hit = fall;
      SENSE_RISE:  hit = rise;
      default:     hit = rise | fall;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
      req_o  <= 1'b0;
    end else begin
      prev_q <= line_i;
      req_o  <= hit;
      if (mode_e == SENSE_LEVEL)
        pend_o <= line_i;
      else if (hit)
        pend_o <= 1'b1;
      else if (clr_i)
        pend_o <= 1'b0;
    end
  end

  generate
    if (PROG) begin : g_prog
      always_ff @(posedge clk) begin
        if (rst)
          mode_o <= RST_MODE;
        else if (mode_we_i)
          mode_o <= mode_wval_i;
      end
      // R7: programmed mode takes the written field
      a_r7_mode_load: assert property (@(posedge clk) disable iff (rst)
        mode_we_i |=> mode_o == $past(mode_wval_i));
    end else begin : g_fixed
      logic unused_wr;
      assign unused_wr = &{1'b0, mode_we_i, mode_wval_i};
      assign mode_o = RST_MODE;
    end
  endgenerate

  // R2: level mode tracks the sampled line
  a_r2_level_tracks: assert property (@(posedge clk) disable iff (rst)
    mode_e == SENSE_LEVEL |=> (pend_o == $past(line_i)) && (req_o == $past(line_i)));
  // R3, R11: rising event sets pending even with a clear in the same cycle
  a_r3_rise_sets: assert property (@(posedge clk) disable iff (rst)
    (mode_e == SENSE_RISE && line_i && !prev_q) |=> pend_o && req_o);
  // R4: falling event sets pending
  a_r4_fall_sets: assert property (@(posedge clk) disable iff (rst)
    (mode_e == SENSE_FALL && !line_i && prev_q) |=> pend_o && req_o);
  // R8: an edge source with no event and no clear keeps its flag
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_e != SENSE_LEVEL && !clr_i && pend_o) |=> pend_o);

endmodule

// File: rtl/sense_wr_decode.sv
module sense_wr_decode #(
  parameter int NUM_SRC = 256,
  parameter int NUM_PIN = 32,
  localparam int SRC_AW = $clog2(NUM_SRC)
) (
  input  logic                wr_en_i,
  input  logic                wr_pin_i,
  input  logic [SRC_AW-1:0]   wr_addr_i,
  input  logic [7:0]          wr_data_i,
  output logic [NUM_SRC-1:0]  clr_o,
  output logic [NUM_PIN-1:0]  mode_we_o,
  output logic [1:0]          mode_wval_o
);

  logic clr_any, pin_any;

  assign clr_any     = wr_en_i && !wr_pin_i && (wr_data_i == 8'h00);
  assign pin_any     = wr_en_i && wr_pin_i;
  assign mode_wval_o = wr_data_i[sense_det_pkg::MODE_LSB +: 2];

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
      assign clr_o[i] = clr_any && (wr_addr_i == SRC_AW'(i));
    end
    for (genvar k = 0; k < NUM_PIN; k++) begin : g_pin
      assign mode_we_o[k] = pin_any && (wr_addr_i == SRC_AW'(k));
    end
  endgenerate

endmodule

// File: rtl/sense_withdraw.sv
module sense_withdraw #(
  parameter int NUM_SRC = 256,
  localparam int SRC_AW = $clog2(NUM_SRC)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_SRC-1:0][1:0] mode_i,
  input  logic [NUM_SRC-1:0]      line_i,
  input  logic                    pres_valid_i,
  input  logic [SRC_AW-1:0]       pres_idx_i,
  output logic                    cancel_o
);

  logic lvl_low;

  assign lvl_low = (mode_i[pres_idx_i] == sense_det_pkg::SENSE_LEVEL) && !line_i[pres_idx_i];

  always_ff @(posedge clk) begin
    if (rst) cancel_o <= 1'b0;
    else     cancel_o <= pres_valid_i && lvl_low;
  end

  // R10: a withdraw only follows a presented source
  a_r10_needs_present: assert property (@(posedge clk) disable iff (rst)
    cancel_o |-> $past(pres_valid_i));
  // R10: no withdraw when nothing is presented
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !pres_valid_i |=> !cancel_o);

endmodule

// File: rtl/sense_detector_array.sv
module sense_detector_array
  import sense_det_pkg::*;
#(
  parameter int NUM_SRC  = 256,
  parameter int PIN_BASE = 64,
  parameter int NUM_PIN  = 32,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = NUM_SRC'((256'h1 << 200) | (256'hF << 64)),
  localparam int SRC_AW  = $clog2(NUM_SRC),
  localparam int PIN_AW  = $clog2(NUM_PIN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_line_i,
  input  logic               wr_en_i,
  input  logic               wr_pin_i,
  input  logic [SRC_AW-1:0]  wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic               rd_pin_i,
  input  logic [SRC_AW-1:0]  rd_addr_i,
  input  logic               pres_valid_i,
  input  logic [SRC_AW-1:0]  pres_idx_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] req_o,
  output logic               cancel_o,
  output logic [7:0]         rd_data_o
);

  logic [NUM_SRC-1:0]      clr_vec;
  logic [NUM_PIN-1:0]      pin_we;
  logic [1:0]              mode_wval;
  logic [NUM_SRC-1:0]      cell_we;
  logic [NUM_SRC-1:0][1:0] cell_mode;

  sense_wr_decode #(.NUM_SRC(NUM_SRC), .NUM_PIN(NUM_PIN)) u_dec (
    .wr_en_i     (wr_en_i),
    .wr_pin_i    (wr_pin_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .clr_o       (clr_vec),
    .mode_we_o   (pin_we),
    .mode_wval_o (mode_wval)
  );

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam bit IS_PIN = (i >= PIN_BASE) && (i < PIN_BASE + NUM_PIN);
      if (IS_PIN) begin : g_we
        assign cell_we[i] = pin_we[i - PIN_BASE];
      end else begin : g_nowe
        assign cell_we[i] = 1'b0;
      end
      sense_cell #(
        .RST_MODE (LEVEL_MASK[i] ? SENSE_LEVEL : SENSE_RISE),
        .PROG     (IS_PIN)
      ) u_cell (
        .clk         (clk),
        .rst         (rst),
        .line_i      (src_line_i[i]),
        .clr_i       (clr_vec[i]),
        .mode_we_i   (cell_we[i]),
        .mode_wval_i (mode_wval),
        .mode_o      (cell_mode[i]),
        .pend_o      (pend_o[i]),
        .req_o       (req_o[i])
      );
    end
  endgenerate

  sense_withdraw #(.NUM_SRC(NUM_SRC)) u_wd (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (cell_mode),
    .line_i       (src_line_i),
    .pres_valid_i (pres_valid_i),
    .pres_idx_i   (pres_idx_i),
    .cancel_o     (cancel_o)
  );

  logic [SRC_AW-1:0] pin_src;
  logic              pin_ok;
  logic [7:0]        rd_next;

  assign pin_src = SRC_AW'(PIN_BASE) + SRC_AW'(rd_addr_i[PIN_AW-1:0]);
  assign pin_ok  = (rd_addr_i < SRC_AW'(NUM_PIN));

  always_comb begin
    rd_next = 8'h00;
    if (rd_pin_i) begin
      if (pin_ok) rd_next[MODE_LSB +: 2] = cell_mode[pin_src];
    end else begin
      rd_next[0] = pend_o[rd_addr_i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= 8'h00;
    else     rd_data_o <= rd_next;
  end

  // R9: pending reads carry only bit 0
  a_r9_pend_bit0: assert property (@(posedge clk) disable iff (rst)
    !rd_pin_i |=> rd_data_o[7:1] == 7'd0);
  // R7: pin control reads carry only the mode field
  a_r7_pin_field: assert property (@(posedge clk) disable iff (rst)
    rd_pin_i |=> (rd_data_o[7:4] == 4'd0) && (rd_data_o[1:0] == 2'd0));

endmodule

// File: tb/tb_sense_detector_array.sv
`timescale 1ns/1ps
module tb_sense_detector_array;

  localparam int NS = 256;
  localparam logic [NS-1:0] LMASK = (256'h1 << 200) | (256'hF << 64);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] lines = '0;
  logic          wr_en = 1'b0, wr_pin = 1'b0;
  logic [7:0]    wr_addr = '0, wr_data = '0;
  logic          rd_pin = 1'b0;
  logic [7:0]    rd_addr = '0;
  logic          pv = 1'b0;
  logic [7:0]    pidx = '0;
  logic [NS-1:0] pend_o, req_o;
  logic          cancel_o;
  logic [7:0]    rd_data_o;

  always #2 clk = ~clk;

  sense_detector_array dut (
    .clk(clk), .rst(rst), .src_line_i(lines),
    .wr_en_i(wr_en), .wr_pin_i(wr_pin), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_pin_i(rd_pin), .rd_addr_i(rd_addr),
    .pres_valid_i(pv), .pres_idx_i(pidx),
    .pend_o(pend_o), .req_o(req_o), .cancel_o(cancel_o), .rd_data_o(rd_data_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  bit [1:0] m_mode [NS];
  bit       m_prev [NS];
  bit       m_pend [NS];
  bit [1:0] pm     [NS];
  logic [NS-1:0] e_pend, e_req;
  logic          e_cancel;
  logic [7:0]    e_rd;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(bit [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R4";
      2'd2: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NS; i++) begin
      m_mode[i] = LMASK[i] ? 2'd0 : 2'd2;
      m_prev[i] = 1'b0;
      m_pend[i] = 1'b0;
    end
  endtask

  // compute expected state for the coming edge from the requirements
  task automatic model_step();
    bit hit, clr;
    e_rd = 8'h00;
    if (rd_pin) begin
      if (rd_addr < 8'd32) e_rd = {4'd0, m_mode[64 + int'(rd_addr)], 2'd0};
    end else begin
      e_rd = {7'd0, m_pend[rd_addr]};
    end
    e_cancel = pv && (m_mode[pidx] == 2'd0) && !lines[pidx];
    for (int i = 0; i < NS; i++) begin
      pm[i] = m_mode[i];
      case (m_mode[i])
        2'd0: hit = lines[i];
        2'd1: hit = m_prev[i] && !lines[i];
        2'd2: hit = !m_prev[i] && lines[i];
        default: hit = m_prev[i] != lines[i];
      endcase
      clr = wr_en && !wr_pin && (int'(wr_addr) == i) && (wr_data == 8'h00);
      e_req[i] = hit;
      if (m_mode[i] == 2'd0)   m_pend[i] = lines[i];
      else if (hit)            m_pend[i] = 1'b1;
      else if (clr)            m_pend[i] = 1'b0;
      m_prev[i] = lines[i];
      e_pend[i] = m_pend[i];
    end
    if (wr_en && wr_pin && wr_addr < 8'd32) m_mode[64 + int'(wr_addr)] = wr_data[3:2];
  endtask

  task automatic compare();
    string t;
    t = "R2";
    for (int i = NS - 1; i >= 0; i--)
      if (pend_o[i] !== e_pend[i] || req_o[i] !== e_req[i]) t = mode_tag(pm[i]);
    n_chk++;
    if (pend_o !== e_pend) begin
      n_fail++;
      $display("FAIL %s pend actual=%h expected=%h", t, pend_o, e_pend);
    end
    n_chk++;
    if (req_o !== e_req) begin
      n_fail++;
      $display("FAIL %s req actual=%h expected=%h", t, req_o, e_req);
    end
    chk("R10 cancel", 32'(cancel_o), 32'(e_cancel));
    chk(rd_pin ? "R7 read" : "R9 read", 32'(rd_data_o), 32'(e_rd));
  endtask

  // called at a falling edge with inputs already set
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    wr_en = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5E15_E0D1));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 pend", 32'(|pend_o), 0);
    chk("R1 req", 32'(|req_o), 0);
    chk("R1 cancel", 32'(cancel_o), 0);
    rd_pin = 1'b1; rd_addr = 8'd0; tick();
    chk("R1 pin0 level", 32'(rd_data_o), 32'h00);
    rd_addr = 8'd10; tick();
    chk("R1 pin10 rise", 32'(rd_data_o), 32'h08);

    // R2: level source 200
    lines[200] = 1'b1; tick();
    chk("R2 set", 32'(pend_o[200]), 1);
    chk("R2 req", 32'(req_o[200]), 1);
    // R10: presented level source drops
    pv = 1'b1; pidx = 8'd200; lines[200] = 1'b0; tick();
    chk("R2 clear", 32'(pend_o[200]), 0);
    chk("R10 withdraw", 32'(cancel_o), 1);
    // R10: edge source presented with low line
    pidx = 8'd10; tick();
    chk("R10 edge quiet", 32'(cancel_o), 0);
    pv = 1'b0;

    // R7: program pin 5 to falling with junk bits
    wr_en = 1'b1; wr_pin = 1'b1; wr_addr = 8'd5; wr_data = 8'hF4; tick();
    rd_pin = 1'b1; rd_addr = 8'd5; tick();
    chk("R7 readback", 32'(rd_data_o), 32'h04);
    // R4: falling event on source 69
    lines[69] = 1'b1; tick();
    chk("R4 no event on rise", 32'(pend_o[69]), 0);
    lines[69] = 1'b0; tick();
    chk("R4 fall sets", 32'(pend_o[69]), 1);
    chk("R4 strobe", 32'(req_o[69]), 1);
    tick();
    chk("R4 strobe one cycle", 32'(req_o[69]), 0);
    // R8: non-zero write ignored, zero clears
    wr_en = 1'b1; wr_pin = 1'b0; wr_addr = 8'd69; wr_data = 8'h02; tick();
    chk("R8 nonzero ignored", 32'(pend_o[69]), 1);
    rd_pin = 1'b0; rd_addr = 8'd69; tick();
    chk("R9 pend read", 32'(rd_data_o), 32'h01);
    wr_en = 1'b1; wr_pin = 1'b0; wr_addr = 8'd69; wr_data = 8'h00; tick();
    chk("R8 zero clears", 32'(pend_o[69]), 0);
    // R8: level source not cleared by software
    lines[200] = 1'b1; wr_en = 1'b1; wr_pin = 1'b0; wr_addr = 8'd200; wr_data = 8'h00; tick();
    chk("R8 level kept", 32'(pend_o[200]), 1);
    // R11: rising event and clear together on source 10
    lines[10] = 1'b1; wr_en = 1'b1; wr_pin = 1'b0; wr_addr = 8'd10; wr_data = 8'h00; tick();
    chk("R11 set wins", 32'(pend_o[10]), 1);
    // R6: source 64 level high, then switched to rising while high
    lines[64] = 1'b1; tick();
    wr_en = 1'b1; wr_pin = 1'b1; wr_addr = 8'd0; wr_data = 8'h08; tick();
    tick();
    chk("R6 no event after switch", 32'(req_o[64]), 0);
    // R7: address beyond the pin window ignored
    wr_en = 1'b1; wr_pin = 1'b1; wr_addr = 8'd40; wr_data = 8'h0C; tick();
    rd_pin = 1'b1; rd_addr = 8'd8; tick();
    chk("R7 out of window", 32'(rd_data_o), 32'h08);
    // R5: both edges on pin 20 (source 84)
    wr_en = 1'b1; wr_pin = 1'b1; wr_addr = 8'd20; wr_data = 8'h0C; tick();
    lines[84] = 1'b1; tick();
    chk("R5 rise", 32'(req_o[84]), 1);
    lines[84] = 1'b0; tick();
    chk("R5 fall", 32'(req_o[84]), 1);

    // random phase
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < NS; i++)
        if ($urandom_range(7) == 0) lines[i] = ~lines[i];
      if ($urandom_range(3) == 0) begin
        wr_en  = 1'b1;
        wr_pin = $urandom_range(1) == 1;
        wr_addr = wr_pin ? 8'($urandom_range(40)) : 8'($urandom_range(255));
        wr_data = ($urandom_range(1) == 1) ? 8'h00 : 8'($urandom_range(255));
      end
      rd_pin  = $urandom_range(1) == 1;
      rd_addr = rd_pin ? 8'($urandom_range(40)) : 8'($urandom_range(255));
      pv      = $urandom_range(1) == 1;
      pidx    = ($urandom_range(1) == 1) ? 8'(64 + $urandom_range(31)) : 8'($urandom_range(255));
      tick();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule